// File: doc/BRIEF.md
# TDM8 Serial Audio Transmitter

This block turns eight parallel 24-bit audio samples into one eight-slot TDM serial stream for a DAC. It runs entirely from the TDM bit clock. It produces a frame-sync output, `fsync`, and a serial data line, `sdata`. Both change only on falling edges of the bit clock, so the receiver can sample them on rising edges. A frame is 256 bit clocks long and is split into eight 32-clock slots. Channel 1 goes in the first slot and channel 8 in the last. A frame begins with the rising edge of the frame sync.

Software, or an upstream block, presents all eight samples on `chan_data` and pulses `load_stb` for one bit clock. The samples go into a staging store. At the first bit clock of every frame, the staging store and the `pulse_len` setting are copied into a frame buffer. A load made part way through a frame therefore only affects the next frame. If no new load arrives, the last samples are sent again.

A two-state controller sequences the block:
- `S_IDLE` is entered on reset. Both outputs are held low.
- The transition `IDLE_TO_RUN` fires on the first `load_stb`.
- `S_RUN` then sends frames back to back for as long as reset stays released. An 8-bit position counter sweeps the frame. Its upper three bits pick the slot and its lower five bits pick the bit within the slot.

Top module: `tdm8_serializer`

## Requirements
- R1: While reset is asserted, and until the first `load_stb` after reset, `fsync` and `sdata` are both 0.
- R2: The falling edge after the one that captures the first `load_stb` starts a frame: `fsync` rises there. Frames then follow every 256 bit clocks with no gap.
- R3: `fsync` is high for the first N bit clocks of each frame and low for the rest. N is the `pulse_len` value captured at frame start, from 1 to 255.
- R4: A `pulse_len` of 0 gives a frame sync exactly 1 bit clock wide.
- R5: Bit position 0 of every slot carries 0. This is the one-clock data delay.
- R6: Positions 1 to 24 of slot k (k = 0..7) carry `chan_data[24k+23:24k]`, most significant bit first. Channel 1 is bits 23:0.
- R7: Positions 25 to 31 of every slot carry 0.
- R8: Samples captured by `load_stb` are sent from the next frame start onward. A load during a frame does not change that frame. Without a new load, the previous samples repeat.
- R9: `fsync` and `sdata` change only on falling edges of `bck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bck | input | 1 | TDM bit clock (256 x sample rate); the logic acts on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_stb | input | 1 | One-clock strobe that captures `chan_data` into the staging store |
| pulse_len | input | 8 | Frame-sync high width in bit clocks; 0 is treated as 1 |
| chan_data | input | 192 | Eight 24-bit samples; channel k+1 at bits 24k+23:24k |
| fsync | output | 1 | Frame sync; its rising edge marks a frame start |
| sdata | output | 1 | Serial TDM data, MSB first |

## Verification
The embedded assertions check the following on every falling edge:
- outputs stay quiet in the idle state;
- the frame sync is high at each frame head;
- a 1-wide pulse drops after one clock;
- each slot has a zero delay bit and a zeroed tail.

Three behaviours can only be shown by the bench's scenarios, which compare every clock against a behavioural frame model:
- the correct sample bit lands at each position of each slot;
- a load in the middle of a frame waits for the next frame;
- the pulse widths 0, 1, 32 and 255 each take effect.

// File: rtl/tdm8_pkg.sv
package tdm8_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } tx_state_t;
endpackage

// File: rtl/tdm8_frame_ctrl.sv
module tdm8_frame_ctrl #(
    parameter int CHANNELS  = 8,
    parameter int SLOT_BITS = 32,
    parameter int PW_W      = 8,
    localparam int SLOT_W   = $clog2(CHANNELS),
    localparam int POS_W    = $clog2(SLOT_BITS),
    localparam int CNT_W    = SLOT_W + POS_W
) (
    input  logic              bck,
    input  logic              rst_n,
    input  logic              load_stb,
    input  logic [PW_W-1:0]   pulse_len,
    output logic              running_o,
    output logic              frame_start_o,
    output logic [SLOT_W-1:0] slot_idx_o,
    output logic [POS_W-1:0]  bit_pos_o,
    output logic              fsync_o
);
    import tdm8_pkg::*;

    tx_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [PW_W-1:0]  len_q;
    logic [PW_W-1:0]  len_eff;
    logic             in_pulse;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (load_stb) state_d = S_RUN;   // IDLE_TO_RUN
            S_RUN:  state_d = S_RUN;
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(negedge bck or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    assign running_o     = (state_q == S_RUN);
    assign frame_start_o = running_o && (cnt_q == '0);
    assign slot_idx_o    = cnt_q[CNT_W-1:POS_W];
    assign bit_pos_o     = cnt_q[POS_W-1:0];
    assign len_eff       = (pulse_len == '0) ? PW_W'(1) : pulse_len;
    assign in_pulse      = ({{(32-CNT_W){1'b0}}, cnt_q} < {{(32-PW_W){1'b0}}, len_q});

    // Outputs and frame counters
    always_ff @(negedge bck or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            len_q   <= PW_W'(1);
            fsync_o <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    cnt_q   <= '0;
                    fsync_o <= 1'b0;
                end
                S_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == '0) begin
                        len_q   <= len_eff;
                        fsync_o <= 1'b1;
                    end else begin
                        fsync_o <= in_pulse;
                    end
                end
                default: begin
                    cnt_q   <= '0;
                    fsync_o <= 1'b0;
                end
            endcase
        end
    end

    assert_idle_quiet_R1: assert property (@(negedge bck) disable iff (!rst_n)
        (state_q == S_IDLE) |=> !fsync_o);

    assert_frame_head_R2: assert property (@(negedge bck) disable iff (!rst_n)
        frame_start_o |=> fsync_o);

    assert_short_pulse_R4: assert property (@(negedge bck) disable iff (!rst_n)
        (running_o && cnt_q == CNT_W'(1) && len_q == PW_W'(1)) |=> !fsync_o);
endmodule

// File: rtl/tdm8_sample_buf.sv
module tdm8_sample_buf #(
    parameter int CHANNELS    = 8,
    parameter int SLOT_BITS   = 32,
    parameter int SAMPLE_BITS = 24,
    localparam int SLOT_W     = $clog2(CHANNELS),
    localparam int POS_W      = $clog2(SLOT_BITS),
    localparam int IDX_W      = $clog2(SAMPLE_BITS),
    localparam int BUS_W      = CHANNELS * SAMPLE_BITS
) (
    input  logic              bck,
    input  logic              rst_n,
    input  logic              load_stb,
    input  logic [BUS_W-1:0]  chan_data,
    input  logic              running,
    input  logic              frame_start,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic [POS_W-1:0]  bit_pos,
    output logic              sdata_o
);
    logic [SAMPLE_BITS-1:0] stage_q  [CHANNELS];
    logic [SAMPLE_BITS-1:0] shadow_q [CHANNELS];
    logic [SAMPLE_BITS-1:0] cur_word;
    logic [IDX_W-1:0]       sel_idx;
    logic                   in_payload;

    for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
        always_ff @(negedge bck or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[ch]  <= '0;
                shadow_q[ch] <= '0;
            end else begin
                if (frame_start) shadow_q[ch] <= stage_q[ch];
                if (load_stb)    stage_q[ch]  <= chan_data[ch*SAMPLE_BITS +: SAMPLE_BITS];
            end
        end
    end

    assign cur_word   = shadow_q[slot_idx];
    assign in_payload = (bit_pos != '0) && (int'(bit_pos) <= SAMPLE_BITS);
    assign sel_idx    = IDX_W'(SAMPLE_BITS - int'(bit_pos));

    always_ff @(negedge bck or negedge rst_n) begin
        if (!rst_n)                     sdata_o <= 1'b0;
        else if (running && in_payload) sdata_o <= cur_word[sel_idx];
        else                            sdata_o <= 1'b0;
    end

    assert_delay_bit_R5: assert property (@(negedge bck) disable iff (!rst_n)
        (running && bit_pos == '0) |=> !sdata_o);

    assert_tail_low_R7: assert property (@(negedge bck) disable iff (!rst_n)
        (running && int'(bit_pos) > SAMPLE_BITS) |=> !sdata_o);
endmodule

// File: rtl/tdm8_serializer.sv
module tdm8_serializer #(
    parameter int CHANNELS    = 8,
    parameter int SLOT_BITS   = 32,
    parameter int SAMPLE_BITS = 24,
    parameter int PW_W        = 8,
    localparam int SLOT_W     = $clog2(CHANNELS),
    localparam int POS_W      = $clog2(SLOT_BITS),
    localparam int BUS_W      = CHANNELS * SAMPLE_BITS
) (
    input  logic             bck,
    input  logic             rst_n,
    input  logic             load_stb,
    input  logic [PW_W-1:0]  pulse_len,
    input  logic [BUS_W-1:0] chan_data,
    output logic             fsync,
    output logic             sdata
);
    logic              running;
    logic              frame_start;
    logic [SLOT_W-1:0] slot_idx;
    logic [POS_W-1:0]  bit_pos;

    tdm8_frame_ctrl #(
        .CHANNELS (CHANNELS),
        .SLOT_BITS(SLOT_BITS),
        .PW_W     (PW_W)
    ) u_ctrl (
        .bck          (bck),
        .rst_n        (rst_n),
        .load_stb     (load_stb),
        .pulse_len    (pulse_len),
        .running_o    (running),
        .frame_start_o(frame_start),
        .slot_idx_o   (slot_idx),
        .bit_pos_o    (bit_pos),
        .fsync_o      (fsync)
    );

    tdm8_sample_buf #(
        .CHANNELS   (CHANNELS),
        .SLOT_BITS  (SLOT_BITS),
        .SAMPLE_BITS(SAMPLE_BITS)
    ) u_buf (
        .bck        (bck),
        .rst_n      (rst_n),
        .load_stb   (load_stb),
        .chan_data  (chan_data),
        .running    (running),
        .frame_start(frame_start),
        .slot_idx   (slot_idx),
        .bit_pos    (bit_pos),
        .sdata_o    (sdata)
    );
endmodule

// File: tb/tdm8_serializer_test.sv
module tdm8_serializer_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 8;
    localparam int SB  = 24;

    logic          bck = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_stb = 1'b0;
    logic [7:0]    pulse_len = 8'd1;
    logic [191:0]  chan_data = '0;
    logic          fsync, sdata;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) bck = ~bck;

    tdm8_serializer uut (
        .bck(bck), .rst_n(rst_n), .load_stb(load_stb), .pulse_len(pulse_len),
        .chan_data(chan_data), .fsync(fsync), .sdata(sdata)
    );

    // Behavioural frame model, advanced on each falling edge
    bit          m_run = 0;
    int          m_pos = 0;
    int          m_len = 1;
    int          m_len_raw = 1;
    logic [23:0] m_stage [NCH];
    logic [23:0] m_frame [NCH];
    logic        exp_fs = 0, exp_sd = 0;
    int          exp_pos = -1;
    bit          exp_run = 0;
    bit          pend_load = 0;

    initial for (int i = 0; i < NCH; i++) begin m_stage[i] = '0; m_frame[i] = '0; end

    always @(negedge bck or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_pos = 0; exp_fs = 0; exp_sd = 0; exp_run = 0; exp_pos = -1;
            for (int i = 0; i < NCH; i++) begin m_stage[i] = '0; m_frame[i] = '0; end
        end else if (!m_run) begin
            exp_fs = 0; exp_sd = 0; exp_run = 0; exp_pos = -1;
            if (load_stb) begin
                for (int i = 0; i < NCH; i++) m_stage[i] = chan_data[i*SB +: SB];
                m_run = 1; m_pos = 0;
            end
        end else begin
            int b;
            if (m_pos == 0) begin
                for (int i = 0; i < NCH; i++) m_frame[i] = m_stage[i];
                m_len_raw = int'(pulse_len);
                m_len = (pulse_len == 0) ? 1 : int'(pulse_len);
                pend_load = 0;
            end
            b = m_pos % 32;
            exp_fs = (m_pos < m_len);
            exp_sd = (b >= 1 && b <= SB) ? m_frame[m_pos / 32][SB - b] : 1'b0;
            exp_run = 1; exp_pos = m_pos;
            if (load_stb) begin
                for (int i = 0; i < NCH; i++) m_stage[i] = chan_data[i*SB +: SB];
                pend_load = 1;
            end
            m_pos = (m_pos + 1) % 256;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    function automatic string fs_tag();
        if (!exp_run)       return "R1";
        if (exp_pos == 0)   return "R2";
        if (m_len_raw == 0) return "R4";
        return "R3";
    endfunction

    function automatic string sd_tag();
        int b;
        if (!exp_run) return "R1";
        b = exp_pos % 32;
        if (b == 0)   return "R5";
        if (b > SB)   return "R7";
        return pend_load ? "R6/R8" : "R6";
    endfunction

    // Snapshot just after each falling edge for the R9 stability check
    logic snap_fs = 0, snap_sd = 0;
    always @(negedge bck) begin #1; snap_fs = fsync; snap_sd = sdata; end

    // Compare on every rising edge
    always @(posedge bck) begin
        check(fsync === exp_fs, fs_tag(), int'(fsync), int'(exp_fs));
        check(sdata === exp_sd, sd_tag(), int'(sdata), int'(exp_sd));
        if (rst_n) begin
            check(fsync === snap_fs && sdata === snap_sd, "R9",
                  int'({fsync, sdata}), int'({snap_fs, snap_sd}));
        end
    end

    function automatic logic [191:0] pattern(input int seed);
        logic [191:0] v;
        for (int k = 0; k < NCH; k++)
            v[k*SB +: SB] = 24'((seed * (k + 3) * 32'h9E3779) ^ (k << 20) ^ seed);
        return v;
    endfunction

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge bck);
    endtask

    task automatic do_load(input logic [191:0] d);
        @(posedge bck); #1;
        chan_data = d; load_stb = 1'b1;
        @(posedge bck); #1;
        load_stb = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R1: reset state, then idle without a load
        wait_cycles(4);
        @(posedge bck); #1; rst_n = 1'b1;
        chan_data = pattern(99);
        wait_cycles(20);
        // R2/R6: first load starts framing, width 1 pulse
        pulse_len = 8'd1;
        do_load(pattern(1));
        wait_cycles(100);
        // R8: mid-frame load must wait for the next frame
        do_load(pattern(2));
        wait_cycles(300);
        // R4: zero width acts as one
        @(posedge bck); #1; pulse_len = 8'd0;
        wait_cycles(260);
        // R3: maximum width
        @(posedge bck); #1; pulse_len = 8'd255;
        do_load({8{24'hFFFFFF}});
        wait_cycles(300);
        // R3: one slot wide, alternating and edge-bit patterns
        @(posedge bck); #1; pulse_len = 8'd32;
        do_load({4{24'h800001, 24'h000000}});
        wait_cycles(280);
        do_load({8{24'hA5A5A5}});
        wait_cycles(520);
        // R8: repeat with no new load
        wait_cycles(300);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule